// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a 12-bit differential successive-approximation converter that is read over a three-wire synchronous link: an active-low select, a data clock driven by the host and a single data line driven by the converter. One start request runs one frame. The controller pulls select low with the data clock parked low and toggles the data clock from a programmable divider of the system clock. It gives the converter two data clock periods to acquire its input, then captures twelve result bits, most significant first. It raises select and returns the code as a signed two's-complement word.

The half-period of the data clock is a configuration input counted in system clocks. Values below two are raised to two, and the value is latched when a frame starts. The result leaves the block as a word plus a one-cycle strobe. The block has no back-pressure. The consumer takes the word in the strobe cycle, and the word then stays on the bus unchanged until the next frame completes. The busy flag covers the whole frame and a closing gap in which select stays high for one full data clock period.

Top module: `adc_rd_ctl`

## Requirements
- R1: While reset is high at a clock edge, the controller afterwards shows select high, data clock low, busy low and the strobe low.
- R2: A start seen while idle pulls select low at that edge with the data clock low. The first data clock rising edge follows H system clocks later. H is the configured half-period, or 2 when the configuration is below 2.
- R3: Every high and every low half of the data clock lasts H system clocks. A frame has exactly 14 rising edges: 2 for acquisition and 12 for data.
- R4: The data line is sampled at the system clock edge where the data clock goes high, on rising edges 3 to 14 only. Rising edge 3 gives bit 11 (the MSB) and rising edge 14 gives bit 0.
- R5: The captured 12 bits are presented unchanged as a two's-complement sample. 800h (-2048) and 7FFh (+2047) come out as 800h and 7FFh.
- R6: The strobe is high for exactly one system clock, in the cycle right after rising edge 14. The sample holds its value after the strobe until the next frame completes.
- R7: Select rises at the same edge as the data clock falls after rising edge 14. The data clock is low whenever select is high.
- R8: After select rises, busy stays high for 2H system clocks before idle. A whole frame keeps busy high for 30H system clocks.
- R9: A start request while busy has no effect: one strobe, 14 rising edges and 30H busy cycles per accepted start.
- R10: A configuration change during a frame does not change that frame's half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request, taken only while idle |
| half_cfg_i | input | DIV_W (8) | Data clock half-period in system clocks |
| cs_n_o | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Data clock to the converter |
| sdo_i | input | 1 | Serial result bit from the converter |
| busy_o | output | 1 | High from accepted start to end of closing gap |
| sample_o | output | DATA_W (12) | Two's-complement result |
| sample_vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest case to reach from the ports is a start request or a configuration change that lands in the middle of a running frame. The controller must neither restart nor stretch its clock. The bench holds a frame open at a slow divider and pulses start partway through the data phase. At the same time it drops the configured half-period. It then checks the strobe count, the rising edge count, the measured high-phase length and the total busy time against the values the original setting predicts. A second hard case is a reset in the middle of a frame. The bench asserts reset during the data phase and expects the idle state right away, then a clean next frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_rd_clkgen.sv
// Data clock generator: toggles every half_i system clocks while run_i.
module adc_rd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             at_lim;

  assign at_lim = run_i && (cnt_q == (half_i - ONE));
  assign rise_o = at_lim && !sclk_q;
  assign fall_o = at_lim && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (at_lim) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + ONE;
    end
  end

  // half-period is never shorter than two system clocks
  assert_min_half_hi_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_q) |=> sclk_q);
  assert_min_half_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (run_i && $fell(sclk_q)) |=> !sclk_q);
endmodule

// File: rtl/adc_rd_shifter.sv
// Serial-to-parallel capture and result register.
module adc_rd_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              last_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[DATA_W-2:0], sdo_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      sample_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= last_i;
      if (cap_i) sh_q <= sh_nxt;
      if (last_i) sample_o <= sh_nxt;
    end
  end

  assert_vld_single_R6: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> $stable(sample_o) || $past(rst));
endmodule

// File: rtl/adc_rd_seq.sv
// Frame sequencer: acquisition, data phase and closing select-high gap.
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ACQ_CLKS = 2,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_cfg_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             run_o,
  output logic             busy_o,
  output logic             cs_n_o,
  output logic [DIV_W-1:0] half_o,
  output logic             cap_o,
  output logic             last_o
);
  localparam int TOTAL = ACQ_CLKS + DATA_W;
  localparam int RC_W  = $clog2(TOTAL + 1);
  localparam int GAP_W = DIV_W + 1;
  localparam logic [RC_W-1:0]  RC_ONE  = RC_W'(1);
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  seq_state_t       state_q;
  logic [RC_W-1:0]  rise_q;
  logic [GAP_W-1:0] gap_q;
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] eff_half;
  logic [GAP_W-1:0] gap_lim;
  logic             frame_end;

  assign eff_half  = (half_cfg_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_cfg_i;
  assign gap_lim   = {half_q, 1'b0} - GAP_ONE;
  assign frame_end = (state_q == ST_XFER) && fall_i && (rise_q == RC_W'(TOTAL));

  assign run_o  = (state_q == ST_XFER);
  assign cs_n_o = (state_q != ST_XFER);
  assign busy_o = (state_q != ST_IDLE);
  assign half_o = half_q;
  assign cap_o  = rise_i && (rise_q >= RC_W'(ACQ_CLKS));
  assign last_o = rise_i && (rise_q == RC_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rise_q  <= '0;
      gap_q   <= '0;
      half_q  <= DIV_W'(MIN_HALF);
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_XFER;
          rise_q  <= '0;
          half_q  <= eff_half;
        end
        ST_XFER: begin
          if (rise_i) rise_q <= rise_q + RC_ONE;
          if (frame_end) begin
            state_q <= ST_GAP;
            gap_q   <= '0;
          end
        end
        ST_GAP: begin
          if (gap_q == gap_lim) state_q <= ST_IDLE;
          else gap_q <= gap_q + GAP_ONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_start_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> !cs_n_o);
  assert_gap_entry_R8: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (cs_n_o && busy_o && gap_q == '0));
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP && gap_q != gap_lim && start_i) |=> state_q == ST_GAP);
  assert_half_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(half_q));
endmodule

// File: rtl/adc_rd_ctl.sv
// Top: host-side readout controller for a three-wire serial converter.
module adc_rd_ctl #(
  parameter int DATA_W   = 12,
  parameter int ACQ_CLKS = 2,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  half_cfg_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  input  logic              sdo_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] sample_o,
  output logic              sample_vld_o
);
  logic             run;
  logic             rise;
  logic             fall;
  logic             cap;
  logic             last;
  logic [DIV_W-1:0] half;

  adc_rd_seq #(
    .DATA_W  (DATA_W),
    .ACQ_CLKS(ACQ_CLKS),
    .DIV_W   (DIV_W),
    .MIN_HALF(MIN_HALF)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .half_cfg_i(half_cfg_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .run_o     (run),
    .busy_o    (busy_o),
    .cs_n_o    (cs_n_o),
    .half_o    (half),
    .cap_o     (cap),
    .last_o    (last)
  );

  adc_rd_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk   (clk),
    .rst   (rst),
    .run_i (run),
    .half_i(half),
    .sclk_o(sclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  adc_rd_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk     (clk),
    .rst     (rst),
    .cap_i   (cap),
    .last_i  (last),
    .sdo_i   (sdo_i),
    .sample_o(sample_o),
    .vld_o   (sample_vld_o)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cs_n_o && !sclk_o && !sample_vld_o && !busy_o));
  assert_sclk_parked_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);
  assert_vld_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |-> !cs_n_o);
endmodule

// File: tb/adc_rd_ctl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctl_tb_top;
  localparam int DATA_W = 12;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [DIV_W-1:0]  half_cfg_i = 8'd2;
  logic              cs_n_o, sclk_o, busy_o, sample_vld_o;
  logic              sdo_i = 1'b0;
  logic [DATA_W-1:0] sample_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  adc_rd_ctl dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .half_cfg_i(half_cfg_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_i(sdo_i), .busy_o(busy_o),
    .sample_o(sample_o), .sample_vld_o(sample_vld_o)
  );

  // behavioural converter: bits launched on data clock falling edges 2..13
  logic [DATA_W-1:0] resp_code = '0;
  int  fcnt = 0;
  bit  in_frame = 0;
  always @(negedge cs_n_o or posedge cs_n_o or negedge sclk_o) begin
    if (cs_n_o) begin
      in_frame = 0;
      sdo_i = 1'b0;
    end else if (!in_frame) begin
      in_frame = 1;
      fcnt = 0;
    end else begin
      fcnt = fcnt + 1;
      if (fcnt >= 2 && fcnt <= 13) sdo_i = resp_code[13 - fcnt];
    end
  end

  // port monitor, sampled away from the active edge
  int clr_req = 0, clr_seen = 0;
  int rises, lead, hi_run, last_hi, gap, busy_cyc, vld_cnt;
  bit prev_sclk = 0;
  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      rises = 0; lead = 0; hi_run = 0; last_hi = 0;
      gap = 0; busy_cyc = 0; vld_cnt = 0; clr_seen = clr_req;
    end
    if (!cs_n_o && rises == 0 && !sclk_o) lead++;
    if (!cs_n_o && sclk_o && !prev_sclk) rises++;
    if (sclk_o) hi_run++;
    else if (prev_sclk) begin last_hi = hi_run; hi_run = 0; end
    if (cs_n_o && busy_o) gap++;
    if (busy_o) busy_cyc++;
    if (sample_vld_o) vld_cnt++;
    prev_sclk = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1", "select after reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1", "data clock after reset", sclk_o, 0);
    chk(busy_o == 1'b0 && sample_vld_o == 1'b0, "R1", "busy|strobe after reset",
        busy_o | sample_vld_o, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // one frame; poke=1 pokes start and the divider mid-frame (R9, R10)
  task automatic run_frame(input logic [11:0] code, input int cfg, input int h,
                           input bit poke);
    int waited;
    resp_code  = code;
    half_cfg_i = DIV_W'(cfg);
    clr_req++;
    @(negedge clk);
    @(negedge clk);
    pulse_start();
    waited = 0;
    while (!sample_vld_o && waited < 4000) begin
      if (poke && waited == 12 * h) begin
        start_i = 1'b1;
        half_cfg_i = 8'd2;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start_i = 1'b0;
    chk(sample_vld_o == 1'b1, "R6", "strobe seen", sample_vld_o, 1);
    chk(sample_o == code, "R4", "captured word", sample_o, code);
    chk($signed(sample_o) == $signed(code), "R5", "signed value",
        $signed(sample_o), $signed(code));
    chk(!cs_n_o, "R7", "select low at strobe", cs_n_o, 0);
    @(negedge clk);
    chk(sample_vld_o == 1'b0, "R6", "strobe width", sample_vld_o, 0);
    waited = 0;
    while (busy_o && waited < 4000) begin
      if (poke && waited == 2) start_i = 1'b1; else start_i = 1'b0;
      @(negedge clk);
      waited++;
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(lead == h, "R2", "select fall to first rise", lead, h);
    chk(rises == 14, "R3", "rising edges per frame", rises, 14);
    chk(last_hi == h, poke ? "R10" : "R3", "high half length", last_hi, h);
    chk(gap == 2 * h, "R8", "closing gap", gap, 2 * h);
    chk(busy_cyc == 30 * h, poke ? "R9" : "R8", "busy length", busy_cyc, 30 * h);
    chk(vld_cnt == 1, poke ? "R9" : "R6", "strobes per frame", vld_cnt, 1);
    chk(cs_n_o && !sclk_o && !busy_o, "R7", "idle after frame", cs_n_o, 1);
    chk(sample_o == code, "R6", "sample held", sample_o, code);
  endtask

  task automatic test_mid_reset();
    resp_code  = 12'h5A5;
    half_cfg_i = 8'd3;
    pulse_start();
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(cs_n_o && !sclk_o && !busy_o && !sample_vld_o, "R1", "mid-frame reset",
        {cs_n_o, sclk_o, busy_o, sample_vld_o}, 8);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    @(negedge clk);
    test_reset();
    run_frame(12'h800, 2, 2, 1'b0);   // R5 negative full scale
    run_frame(12'h7FF, 3, 3, 1'b0);   // R5 positive full scale
    run_frame(12'hA5C, 0, 2, 1'b0);   // R2 clamp of a zero divider
    run_frame(12'h3C1, 5, 5, 1'b0);   // R4 mixed pattern
    run_frame(12'h6B2, 4, 4, 1'b1);   // R9, R10 pokes during frame
    test_mid_reset();
    run_frame(12'h001, 2, 2, 1'b0);   // R4 after reset recovery
    summary();
  end
endmodule